// File: doc/BRIEF.md
# Character Display Command Sequencer

This block is the host side of an 8-bit parallel character display bus. Software-level agents hand it one request at a time over a valid/ready port. A request is an opcode and an 8-bit argument. The block turns each request into a single bus write and drives the register-select line, the read/write line, the enable strobe and the eight data lanes. The enable strobe goes through a setup phase, a pulse phase and a hold phase, and each phase lasts a whole number of clock cycles.

A display controller needs time to finish an instruction, so the sequencer does not start the next write until the previous one has completed. A parameter picks one of two ways to do this:

- **Polling:** the sequencer issues busy-flag reads, with the data lanes released, and repeats them until the top lane reads low.
- **Timed:** the sequencer waits a fixed worst-case interval. The long interval covers the clear and home instructions. The short interval covers everything else.

Out of reset the block sends a four-instruction configuration sequence by itself. Only after that sequence has finished does it accept requests.

Top module: `chardisp_seq`

## Requirements
- R1: While reset is held, cmd_ready, disp_e and disp_dq_oe are 0. After reset the block writes the instructions 0x38, 0x0C, 0x01 and 0x06, in that order and with no request. cmd_ready first rises only after the fourth of these writes has completed.
- R2: An instruction write drives register-select 0 and read/write 0. A character write drives register-select 1 and read/write 0. In both cases the host drives the data lanes (disp_dq_oe = 1).
- R3: The bus byte for each cmd_op value is:
  - 0 clear: 0x01
  - 1 home: 0x02
  - 2 entry mode: 000001 followed by arg[1:0] (increment, shift)
  - 3 display control: 00001 followed by arg[2:0] (display, cursor, blink)
  - 4 function: 001, then arg[2:0] (width, lines, font), then 00
  - 5 cursor address: 1 followed by arg[6:0]
  - 6 glyph address: 01 followed by arg[5:0]
  - 7 character: arg itself
- R4: Each bus cycle keeps register-select, read/write, the data lanes and the lane drive enable unchanged from the start of setup to the end of hold. disp_e is high for exactly T_PULSE cycles.
- R5: In timed mode, at least LONG_WAIT_CYC cycles pass with disp_e low between the end of a clear or home write and the next rise of disp_e.
- R6: In timed mode, at least SHORT_WAIT_CYC cycles pass with disp_e low between the end of any other write and the next rise of disp_e.
- R7: In polling mode, every write is followed by reads with register-select 0, read/write 1 and the lanes released. The reads repeat until disp_busy_i is sampled 0 at the end of the enable pulse. The next write starts only after that read.
- R8: cmd_ready is high only when no bus cycle or wait is in progress. A request is taken on a cycle with cmd_valid and cmd_ready both high, and cmd_ready is low on the following cycle. While cmd_valid is low, no bus cycle starts.
- R9: In timed mode the block never issues a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block can take a request |
| cmd_op | input | 3 | Request opcode (see R3) |
| cmd_arg | input | 8 | Request argument |
| disp_rs | output | 1 | Register select: 0 instruction, 1 data |
| disp_rw | output | 1 | 1 read, 0 write |
| disp_e | output | 1 | Enable strobe |
| disp_dq_o | output | 8 | Data lanes driven by the host |
| disp_dq_oe | output | 1 | Host drives the data lanes when 1 |
| disp_busy_i | input | 1 | Top data lane as seen by the host |

## Verification
The assertions check the following on every cycle:
- the enable pulse length and the stability of the bus fields within a cycle;
- the idle-cycle gap ahead of each enable rise in timed mode, measured against the class of the preceding write;
- that no write starts in polling mode while a busy flag is outstanding;
- the behaviour of cmd_ready.

Some behaviour only the bench scenarios can show:
- the exact byte and register-select produced for each opcode;
- the order of the start-up sequence;
- that the polling loop issues exactly one more read than the display reports busy;
- that a long idle stretch with no request leaves the bus quiet.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_HOME    = 3'd1,
        OP_ENTRY   = 3'd2,
        OP_DISPCTL = 3'd3,
        OP_FUNC    = 3'd4,
        OP_CURSOR  = 3'd5,
        OP_GLYPH   = 3'd6,
        OP_CHAR    = 3'd7
    } op_e;

    // One bus write: register select, byte, and whether it needs the long wait.
    typedef struct packed {
        logic       rs;
        logic [7:0] data;
        logic       slow;
    } bus_item_t;

    localparam int BOOT_LEN = 4;

    function automatic bus_item_t encode_cmd(input op_e op, input logic [7:0] arg);
        bus_item_t r;
        r = '0;
        case (op)
            OP_CLEAR:   begin r.data = 8'h01; r.slow = 1'b1; end
            OP_HOME:    begin r.data = 8'h02; r.slow = 1'b1; end
            OP_ENTRY:   r.data = {6'b000001, arg[1:0]};
            OP_DISPCTL: r.data = {5'b00001, arg[2:0]};
            OP_FUNC:    r.data = {3'b001, arg[2:0], 2'b00};
            OP_CURSOR:  r.data = {1'b1, arg[6:0]};
            OP_GLYPH:   r.data = {2'b01, arg[5:0]};
            default:    begin r.rs = 1'b1; r.data = arg; end
        endcase
        return r;
    endfunction

    // Start-up configuration: 8-bit, 2 lines, 5x8; display on; clear; increment.
    function automatic bus_item_t boot_item(input logic [1:0] idx);
        case (idx)
            2'd0:    return encode_cmd(OP_FUNC, 8'h06);
            2'd1:    return encode_cmd(OP_DISPCTL, 8'h04);
            2'd2:    return encode_cmd(OP_CLEAR, 8'h00);
            default: return encode_cmd(OP_ENTRY, 8'h02);
        endcase
    endfunction

endpackage

// File: rtl/chardisp_wait.sv
module chardisp_wait #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    assert_counts_down_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) != '0 && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/chardisp_strobe.sv
module chardisp_strobe #(
    parameter int T_SETUP = 4,
    parameter int T_PULSE = 60,
    parameter int T_HOLD  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_rs,
    input  logic       start_rw,
    input  logic [7:0] start_data,
    output logic       done,
    output logic       rd_busy,
    output logic       bus_e,
    output logic       bus_rs,
    output logic       bus_rw,
    output logic [7:0] bus_dq_out,
    output logic       bus_dq_oe,
    input  logic       bus_busy_in
);
    localparam int TMAX = (T_SETUP > T_PULSE) ?
                          ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                          ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW = $clog2(TMAX + 1);
    localparam int LW = $clog2(T_PULSE + 2);

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_PULSE, P_HOLD} phase_e;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          rs;
        logic          rw;
        logic [7:0]    dat;
        logic          done;
        logic          rd;
    } strb_t;

    strb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            P_IDLE: begin
                if (start) begin
                    st_d.phase = P_SETUP;
                    st_d.cnt   = CW'(T_SETUP - 1);
                    st_d.rs    = start_rs;
                    st_d.rw    = start_rw;
                    st_d.dat   = start_data;
                end
            end
            P_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = P_PULSE;
                    st_d.cnt   = CW'(T_PULSE - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            P_PULSE: begin
                if (st_q.cnt == '0) begin
                    st_d.rd    = bus_busy_in;
                    st_d.phase = P_HOLD;
                    st_d.cnt   = CW'(T_HOLD - 1);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = P_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: P_IDLE, default: '0};
        else     st_q <= st_d;
    end

    logic active;
    assign active     = (st_q.phase != P_IDLE);
    assign bus_e      = (st_q.phase == P_PULSE);
    assign bus_rs     = active & st_q.rs;
    assign bus_rw     = active & st_q.rw;
    assign bus_dq_out = active ? st_q.dat : 8'h00;
    assign bus_dq_oe  = active & ~st_q.rw;
    assign done       = st_q.done;
    assign rd_busy    = st_q.rd;

    // Checker-only pulse length counter.
    logic [LW-1:0] elen_q;
    always_ff @(posedge clk) begin
        if (rst)                         elen_q <= '0;
        else if (!bus_e)                 elen_q <= '0;
        else if (elen_q != {LW{1'b1}})   elen_q <= elen_q + 1'b1;
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_e) |-> (elen_q == LW'(T_PULSE)));

    assert_fields_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable({bus_rs, bus_rw, bus_dq_out, bus_dq_oe}));

endmodule

// File: rtl/chardisp_seq.sv
module chardisp_seq
    import chardisp_pkg::*;
#(
    parameter bit USE_POLL       = 1'b1,
    parameter int T_SETUP        = 4,
    parameter int T_PULSE        = 60,
    parameter int T_HOLD         = 4,
    parameter int SHORT_WAIT_CYC = 9500,
    parameter int LONG_WAIT_CYC  = 380000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_arg,
    output logic       disp_rs,
    output logic       disp_rw,
    output logic       disp_e,
    output logic [7:0] disp_dq_o,
    output logic       disp_dq_oe,
    input  logic       disp_busy_i
);
    localparam int TW = $clog2(LONG_WAIT_CYC + 1);
    localparam int BW = $clog2(BOOT_LEN);

    typedef enum logic [2:0] {S_ISSUE, S_WRITE, S_POLL_GO, S_POLL, S_TIMER, S_IDLE} st_e;

    typedef struct packed {
        st_e       st;
        logic [BW-1:0] boot_idx;
        logic      booted;
        bus_item_t cur;
        logic      busy_pend;
        logic      last_slow;
        logic [TW-1:0] gap;
    } seq_t;

    seq_t sq_d, sq_q;

    logic          wr_go, rd_go, fin;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          strb_done, strb_busy;

    always_comb begin
        sq_d     = sq_q;
        wr_go    = 1'b0;
        rd_go    = 1'b0;
        fin      = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (sq_q.st)
            S_ISSUE: begin
                wr_go    = 1'b1;
                sq_d.st  = S_WRITE;
            end
            S_WRITE: begin
                if (strb_done) begin
                    sq_d.last_slow = sq_q.cur.slow;
                    sq_d.busy_pend = 1'b1;
                    if (USE_POLL) begin
                        sq_d.st = S_POLL_GO;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = sq_q.cur.slow ? TW'(LONG_WAIT_CYC) : TW'(SHORT_WAIT_CYC);
                        sq_d.st  = S_TIMER;
                    end
                end
            end
            S_POLL_GO: begin
                rd_go   = 1'b1;
                sq_d.st = S_POLL;
            end
            S_POLL: begin
                if (strb_done) begin
                    if (strb_busy) begin
                        sq_d.st = S_POLL_GO;
                    end else begin
                        sq_d.busy_pend = 1'b0;
                        fin            = 1'b1;
                    end
                end
            end
            S_TIMER: begin
                if (tmr_expired) begin
                    sq_d.busy_pend = 1'b0;
                    fin            = 1'b1;
                end
            end
            default: begin
                if (cmd_valid) begin
                    sq_d.cur = encode_cmd(op_e'(cmd_op), cmd_arg);
                    sq_d.st  = S_ISSUE;
                end
            end
        endcase

        if (fin) begin
            if (sq_q.booted) begin
                sq_d.st = S_IDLE;
            end else if (sq_q.boot_idx == BW'(BOOT_LEN - 1)) begin
                sq_d.booted = 1'b1;
                sq_d.st     = S_IDLE;
            end else begin
                sq_d.boot_idx = sq_q.boot_idx + 1'b1;
                sq_d.cur      = boot_item(sq_q.boot_idx + 1'b1);
                sq_d.st       = S_ISSUE;
            end
        end

        // Checker-only idle-gap counter, saturating.
        if (disp_e)
            sq_d.gap = '0;
        else if (sq_q.gap != TW'(LONG_WAIT_CYC))
            sq_d.gap = sq_q.gap + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q           <= '0;
            sq_q.st        <= S_ISSUE;
            sq_q.cur       <= boot_item('0);
            sq_q.gap       <= TW'(LONG_WAIT_CYC);
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cmd_ready = (sq_q.st == S_IDLE);

    chardisp_strobe #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD)
    ) u_strobe (
        .clk         (clk),
        .rst         (rst),
        .start       (wr_go | rd_go),
        .start_rs    (wr_go & sq_q.cur.rs),
        .start_rw    (rd_go),
        .start_data  (sq_q.cur.data),
        .done        (strb_done),
        .rd_busy     (strb_busy),
        .bus_e       (disp_e),
        .bus_rs      (disp_rs),
        .bus_rw      (disp_rw),
        .bus_dq_out  (disp_dq_o),
        .bus_dq_oe   (disp_dq_oe),
        .bus_busy_in (disp_busy_i)
    );

    chardisp_wait #(.W(TW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assert_long_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (!USE_POLL && $rose(disp_e) && sq_q.last_slow) |-> (sq_q.gap >= TW'(LONG_WAIT_CYC)));

    assert_short_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (!USE_POLL && $rose(disp_e)) |-> (sq_q.gap >= TW'(SHORT_WAIT_CYC)));

    assert_poll_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (USE_POLL && $rose(disp_e) && !disp_rw) |-> !sq_q.busy_pend);

    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!disp_e && !disp_dq_oe));

    assert_no_read_timed_R9: assert property (@(posedge clk) disable iff (rst)
        (!USE_POLL && disp_e) |-> !disp_rw);

endmodule

// File: tb/chardisp_seq_tb.sv
module chardisp_seq_tb;
    localparam int TS = 2, TP = 3, TH = 2;
    localparam int SHORT = 40, LONG = 300;
    localparam int BUSY_READS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       valid_s [2];
    logic       ready_s [2];
    logic [2:0] op_s    [2];
    logic [7:0] arg_s   [2];
    logic       rs_s    [2];
    logic       rw_s    [2];
    logic       e_s     [2];
    logic [7:0] dq_s    [2];
    logic       oe_s    [2];
    logic       poll_busy;
    int         busy_cnt = 0;
    assign poll_busy = (busy_cnt > 0);

    chardisp_seq #(.USE_POLL(1'b1), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
                   .SHORT_WAIT_CYC(SHORT), .LONG_WAIT_CYC(LONG)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(valid_s[0]), .cmd_ready(ready_s[0]),
        .cmd_op(op_s[0]), .cmd_arg(arg_s[0]), .disp_rs(rs_s[0]), .disp_rw(rw_s[0]),
        .disp_e(e_s[0]), .disp_dq_o(dq_s[0]), .disp_dq_oe(oe_s[0]), .disp_busy_i(poll_busy));

    chardisp_seq #(.USE_POLL(1'b0), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
                   .SHORT_WAIT_CYC(SHORT), .LONG_WAIT_CYC(LONG)) u_dut_tmr (
        .clk(clk), .rst(rst), .cmd_valid(valid_s[1]), .cmd_ready(ready_s[1]),
        .cmd_op(op_s[1]), .cmd_arg(arg_s[1]), .disp_rs(rs_s[1]), .disp_rw(rw_s[1]),
        .disp_e(e_s[1]), .disp_dq_o(dq_s[1]), .disp_dq_oe(oe_s[1]), .disp_busy_i(1'b0));

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [8:0] expq0 [$];
    logic [8:0] expq1 [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected {rs, byte} per R3.
    function automatic logic [8:0] expect_of(input int op, input logic [7:0] a);
        case (op)
            0: return 9'h001;
            1: return 9'h002;
            2: return {1'b0, 6'b000001, a[1:0]};
            3: return {1'b0, 5'b00001, a[2:0]};
            4: return {1'b0, 3'b001, a[2:0], 2'b00};
            5: return {1'b0, 1'b1, a[6:0]};
            6: return {1'b0, 2'b01, a[5:0]};
            default: return {1'b1, a};
        endcase
    endfunction

    task automatic push_exp(input int k, input logic [8:0] v);
        if (k == 0) expq0.push_back(v);
        else        expq1.push_back(v);
    endtask

    // Monitor state
    logic       prev_e [2];
    int         hi_cnt [2], gap [2], reads_since [2], writes [2], reads [2];
    logic       last_slow [2], bad [2];
    logic       rs_snap [2], rw_snap [2], oe_snap [2];
    logic [7:0] dq_snap [2];

    initial begin
        for (int k = 0; k < 2; k++) begin
            prev_e[k] = 0; hi_cnt[k] = 0; gap[k] = 0; reads_since[k] = 0;
            writes[k] = 0; reads[k] = 0; last_slow[k] = 0; bad[k] = 0;
            valid_s[k] = 0; op_s[k] = 0; arg_s[k] = 0;
        end
    end

    always @(negedge clk) begin
        logic [8:0] want;
        logic [8:0] got;
        if (!rst) begin
            for (int k = 0; k < 2; k++) begin
                if (e_s[k] && !prev_e[k]) begin
                    rs_snap[k] = rs_s[k]; rw_snap[k] = rw_s[k];
                    dq_snap[k] = dq_s[k]; oe_snap[k] = oe_s[k];
                    hi_cnt[k] = 1; bad[k] = 0;
                    if (!rw_s[k] && writes[k] > 0) begin
                        if (k == 1) begin
                            if (last_slow[k])
                                chk(gap[k] >= LONG, "R5", "idle gap after clear/home", gap[k], LONG);
                            else
                                chk(gap[k] >= SHORT, "R6", "idle gap after write", gap[k], SHORT);
                        end else begin
                            chk(reads_since[k] == BUSY_READS + 1, "R7", "busy reads before write",
                                reads_since[k], BUSY_READS + 1);
                        end
                    end
                    if (!rw_s[k]) reads_since[k] = 0;
                    if (rw_s[k] && k == 1) chk(0, "R9", "read cycle in timed mode", 1, 0);
                end else if (e_s[k] && prev_e[k]) begin
                    hi_cnt[k]++;
                    if (rs_s[k] != rs_snap[k] || rw_s[k] != rw_snap[k] ||
                        dq_s[k] != dq_snap[k] || oe_s[k] != oe_snap[k]) bad[k] = 1;
                end else if (!e_s[k] && prev_e[k]) begin
                    chk(hi_cnt[k] == TP, "R4", "enable pulse width", hi_cnt[k], TP);
                    chk(!bad[k] && rs_s[k] == rs_snap[k] && rw_s[k] == rw_snap[k] &&
                        dq_s[k] == dq_snap[k], "R4", "fields held through pulse", bad[k], 0);
                    if (!rw_snap[k]) begin
                        got = {rs_snap[k], dq_snap[k]};
                        want = 9'h1FF;
                        if (k == 0 && expq0.size() > 0) want = expq0.pop_front();
                        if (k == 1 && expq1.size() > 0) want = expq1.pop_front();
                        chk(got == want, "R3", "written rs/byte", got, want);
                        chk(oe_snap[k] == 1'b1, "R2", "host drives lanes on write", oe_snap[k], 1);
                        writes[k]++;
                        last_slow[k] = !rs_snap[k] && (dq_snap[k] == 8'h01 || dq_snap[k][7:1] == 7'd1);
                        if (k == 0) busy_cnt = BUSY_READS;
                    end else begin
                        chk(oe_snap[k] == 1'b0 && rs_snap[k] == 1'b0, "R7", "read releases lanes, rs=0",
                            {oe_snap[k], rs_snap[k]}, 0);
                        reads[k]++;
                        reads_since[k]++;
                        if (k == 0 && busy_cnt > 0) busy_cnt--;
                    end
                end
                if (e_s[k]) gap[k] = 0; else gap[k]++;
                prev_e[k] = e_s[k];
            end
        end
    end

    task automatic send(input int k, input int op, input logic [7:0] a);
        @(negedge clk);
        while (!ready_s[k]) @(negedge clk);
        push_exp(k, expect_of(op, a));
        valid_s[k] = 1'b1; op_s[k] = 3'(op); arg_s[k] = a;
        @(negedge clk);
        valid_s[k] = 1'b0;
        chk(ready_s[k] == 1'b0, "R8", "ready low after accept", ready_s[k], 0);
    endtask

    task automatic run_seq(input int k);
        int w;
        while (!ready_s[k]) @(negedge clk);
        chk(writes[k] == 4, "R1", "boot writes before first ready", writes[k], 4);
        chk((k == 0 ? expq0.size() : expq1.size()) == 0, "R1", "boot sequence consumed",
            (k == 0 ? expq0.size() : expq1.size()), 0);
        send(k, 0, 8'h00);
        send(k, 1, 8'h00);
        send(k, 2, 8'hFE);
        send(k, 3, 8'h07);
        send(k, 4, 8'h06);
        send(k, 5, 8'hC5);
        send(k, 6, 8'hAA);
        send(k, 7, 8'h41);  // character: R2 rs=1
        send(k, 7, 8'h7E);
        while (!ready_s[k]) @(negedge clk);
        w = writes[k];
        op_s[k] = 3'd7; arg_s[k] = 8'h55;
        repeat (60) @(negedge clk);
        chk(writes[k] == w && reads[k] == (k == 0 ? 3 * w : 0), "R8",
            "no bus cycle while cmd_valid low", writes[k], w);
        chk(ready_s[k] == 1'b1, "R8", "ready held while idle", ready_s[k], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(ready_s[k] == 0, "R1", "ready in reset", ready_s[k], 0);
            chk(e_s[k] == 0 && oe_s[k] == 0, "R1", "bus quiet in reset", {e_s[k], oe_s[k]}, 0);
            push_exp(k, 9'h038);
            push_exp(k, 9'h00C);
            push_exp(k, 9'h001);
            push_exp(k, 9'h006);
        end
        rst = 1'b0;
        fork
            run_seq(0);
            run_seq(1);
        join
        chk(reads[1] == 0, "R9", "timed-mode read count", reads[1], 0);
        chk(reads[0] == (BUSY_READS + 1) * writes[0], "R7", "poll read count",
            reads[0], (BUSY_READS + 1) * writes[0]);
        chk(expq0.size() == 0 && expq1.size() == 0, "R2", "all expected writes seen",
            expq0.size() + expq1.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule